// File: doc/BRIEF.md
# Three-Stage Pipeline Stall Controller

This block steers a small in-order pipeline made of a Fetch, a Decode and an Execute stage. Each instruction carries only an operation-class tag; the controller moves a valid bit and that tag from stage to stage. It decides in each cycle whether the stages advance or freeze, and it reports which stage registers capture a real instruction. No operand-dependency interlock exists, because the pipeline has no data hazards. Every stall has one of four causes: a multi-cycle operation held in Execute, a data-memory or stream access waiting for its ready signal, an instruction fetch that has not returned, or a taken branch.

The multi-cycle classes (barrel shift, multiply, divide, floating point) each keep Execute for a latency set by a parameter. While Execute is busy, Fetch and Decode hold their contents. The next instruction enters Execute in the cycle after the busy one retires. A fetch that is not ready lets the rest of the pipeline drain and puts a bubble into Fetch. A taken branch that retires in Execute removes whatever sits in Fetch and Decode, which leaves two bubbles. In that same cycle the fetch side is assumed to present the branch target, and Fetch captures it.

Top module: `tri_stage_pipe_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, all three stage valid outputs are low after that edge, and x_retire and redirect are low.
- R2: When Execute is not busy, an instruction is captured into Fetch (f_en high, f_valid high in the next cycle) exactly when imem_ready is high. When imem_ready is low, Fetch receives a bubble and stall is high.
- R3: With no stall, a valid instruction moves from Fetch to Decode to Execute one stage per cycle, and a bubble moves the same way. Class codes 0 (plain ALU) and 1 (branch) occupy Execute for one cycle.
- R4: The multi-cycle class codes occupy Execute for exactly their latency, with x_retire high in the last cycle: 5 (barrel shift) for LAT_BSHIFT=2, 6 (multiply) for LAT_MUL=3, 7 (divide) for LAT_DIV=32 and 8 (floating point) for LAT_FPU=4 cycles.
- R5: While the instruction in Execute has not retired, f_valid, d_valid, x_valid and x_class hold their values, stall is high, and f_en, d_en and x_en are low. The next instruction enters Execute in the cycle after the retire.
- R6: Class codes 2 (load) and 3 (store) stay in Execute, with stall high and x_retire low, until dmem_ready is high, and they retire in that cycle.
- R7: Class code 4 (stream access) stays in Execute until strm_ready is high, and it retires in that cycle.
- R8: When a class 1 instruction retires with branch_taken high, redirect is high in that cycle. In the next cycle Decode and Execute hold bubbles, while Fetch holds the instruction presented during the redirect cycle. branch_taken has no effect for any other class, or while the instruction in Execute has not retired.
- R9: Instructions retire in the order they were fetched. None is lost or duplicated by a stall unless a taken branch flushes it.
- R10: dmem_ready and strm_ready have no effect on any class other than the one that waits for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_class | input | 4 | Class tag of the instruction presented by the fetch side |
| imem_ready | input | 1 | Fetch side holds a valid instruction this cycle |
| dmem_ready | input | 1 | Data memory completes the load or store in Execute |
| strm_ready | input | 1 | Stream port completes the stream access in Execute |
| branch_taken | input | 1 | Branch in Execute resolves as taken |
| f_valid | output | 1 | Fetch stage holds an instruction |
| d_valid | output | 1 | Decode stage holds an instruction |
| x_valid | output | 1 | Execute stage holds an instruction |
| x_class | output | 4 | Class tag of the instruction in Execute |
| f_en | output | 1 | Fetch captures the presented instruction at the next edge |
| d_en | output | 1 | Decode captures a valid instruction at the next edge |
| x_en | output | 1 | Execute captures a valid instruction at the next edge |
| stall | output | 1 | No new instruction is accepted from the fetch side this cycle |
| x_retire | output | 1 | Instruction in Execute completes this cycle |
| redirect | output | 1 | Taken branch retires; Fetch and Decode contents are dropped |

## Verification
The case that needs the most care is a branch outcome that arrives in the same cycle as other pipeline activity. One form is branch_taken held high while a multiply is still busy in Execute. The other is a taken branch that retires while Fetch is capturing the next presented instruction. The bench keeps branch_taken high from reset, through the multiply and into the branch. It checks that redirect stays low until the branch itself retires, that Decode and Execute then hold bubbles while Fetch holds a valid instruction, and that the retired classes skip exactly the two flushed entries. A sweep over every ordered pair of classes checks the retire-to-retire gap against the latencies computed from the requirements.

// File: rtl/tsp_pkg.sv
// Shared types for the three-stage pipeline stall controller.
// Assumes class tags fit in CLS_W bits; codes above OPC_FPU behave as plain ALU.
package tsp_pkg;
    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        OPC_ALU    = 4'd0,
        OPC_BRANCH = 4'd1,
        OPC_LOAD   = 4'd2,
        OPC_STORE  = 4'd3,
        OPC_STREAM = 4'd4,
        OPC_BSHIFT = 4'd5,
        OPC_MUL    = 4'd6,
        OPC_DIV    = 4'd7,
        OPC_FPU    = 4'd8
    } op_class_e;

    typedef struct packed {
        logic      vld;
        op_class_e cls;
    } stage_t;

    // Largest of four latencies, used to size the occupancy counter.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/tsp_latency_map.sv
// Maps an operation class to the number of extra Execute cycles it needs.
// Assumes every latency parameter is at least 1; single-cycle classes give 0.
module tsp_latency_map
    import tsp_pkg::*;
#(
    parameter int LAT_BSHIFT = 2,
    parameter int LAT_MUL    = 3,
    parameter int LAT_DIV    = 32,
    parameter int LAT_FPU    = 4,
    parameter int CNT_W      = 5
) (
    input  op_class_e          cls,
    output logic [CNT_W-1:0]   extra
);
    // Latency minus one for the given class.
    always_comb begin
        unique case (cls)
            OPC_BSHIFT: extra = CNT_W'(LAT_BSHIFT - 1);
            OPC_MUL:    extra = CNT_W'(LAT_MUL - 1);
            OPC_DIV:    extra = CNT_W'(LAT_DIV - 1);
            OPC_FPU:    extra = CNT_W'(LAT_FPU - 1);
            default:    extra = '0;
        endcase
    end
endmodule

// File: rtl/tsp_exec_tracker.sv
// Tracks how long the instruction in Execute still needs and whether it
// completes this cycle. Loads the remaining count when Execute advances;
// memory and stream classes additionally wait for their ready inputs.
module tsp_exec_tracker
    import tsp_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load_vld,
    input  logic [CNT_W-1:0] load_extra,
    input  logic             x_vld,
    input  op_class_e        x_cls,
    input  logic             dmem_ready,
    input  logic             strm_ready,
    output logic             done,
    output logic             busy
);
    logic [CNT_W-1:0] remain_q;
    logic             ext_ok;

    // Remaining-cycle counter: reload on advance, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (adv) begin
            remain_q <= load_vld ? load_extra : '0;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // External completion condition per class.
    always_comb begin
        unique case (x_cls)
            OPC_LOAD, OPC_STORE: ext_ok = dmem_ready;
            OPC_STREAM:          ext_ok = strm_ready;
            default:             ext_ok = 1'b1;
        endcase
    end

    // Completion and busy status of Execute.
    always_comb begin
        done = x_vld && (remain_q == '0) && ext_ok;
        busy = x_vld && !done;
    end
endmodule

// File: rtl/tsp_adv_ctrl.sv
// Derives the pipeline advance, per-stage capture enables, stall and redirect.
// Assumes branch outcomes are only meaningful in the cycle a branch retires.
module tsp_adv_ctrl
    import tsp_pkg::*;
(
    input  logic      busy,
    input  logic      done,
    input  op_class_e x_cls,
    input  logic      branch_taken,
    input  logic      imem_ready,
    input  logic      f_vld,
    input  logic      d_vld,
    output logic      adv,
    output logic      redirect,
    output logic      f_en,
    output logic      d_en,
    output logic      x_en,
    output logic      stall
);
    // Advance, flush and enable decisions for this cycle.
    always_comb begin
        adv      = !busy;
        redirect = done && (x_cls == OPC_BRANCH) && branch_taken;
        f_en     = adv && imem_ready;
        d_en     = adv && f_vld && !redirect;
        x_en     = adv && d_vld && !redirect;
        stall    = busy || !imem_ready;
    end
endmodule

// File: rtl/tsp_stage_pipe.sv
// The Fetch, Decode and Execute stage registers (valid bit plus class tag).
// All stages move together on adv; a redirect turns the contents passed into
// Decode and Execute into bubbles, while Fetch captures the fetch side.
module tsp_stage_pipe
    import tsp_pkg::*;
#(
    parameter int N_STG = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      redirect,
    input  logic      imem_ready,
    input  op_class_e fetch_cls,
    output stage_t    f_q,
    output stage_t    d_q,
    output stage_t    x_q
);
    stage_t q   [N_STG];
    stage_t nxt [N_STG];

    for (genvar k = 0; k < N_STG; k++) begin : g_stg
        if (k == 0) begin : g_head
            assign nxt[k] = '{vld: imem_ready, cls: fetch_cls};
        end else begin : g_body
            assign nxt[k] = '{vld: q[k-1].vld && !redirect, cls: q[k-1].cls};
        end

        // Stage register: clear on reset, capture on advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[k] <= '{vld: 1'b0, cls: OPC_ALU};
            end else if (adv) begin
                q[k] <= nxt[k];
            end
        end
    end

    assign f_q = q[0];
    assign d_q = q[1];
    assign x_q = q[N_STG-1];
endmodule

// File: rtl/tri_stage_pipe_ctrl.sv
// Top of the three-stage pipeline stall controller. Connects the stage
// registers, the Execute occupancy tracker and the advance logic.
// Assumes the fetch side keeps presenting the same instruction while stalled
// and presents the branch target in the cycle redirect is high.
module tri_stage_pipe_ctrl
    import tsp_pkg::*;
#(
    parameter int LAT_BSHIFT = 2,
    parameter int LAT_MUL    = 3,
    parameter int LAT_DIV    = 32,
    parameter int LAT_FPU    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  fetch_class,
    input  logic        imem_ready,
    input  logic        dmem_ready,
    input  logic        strm_ready,
    input  logic        branch_taken,
    output logic        f_valid,
    output logic        d_valid,
    output logic        x_valid,
    output logic [3:0]  x_class,
    output logic        f_en,
    output logic        d_en,
    output logic        x_en,
    output logic        stall,
    output logic        x_retire,
    output logic        redirect
);
    localparam int LAT_MAX = max4(LAT_BSHIFT, LAT_MUL, LAT_DIV, LAT_FPU);
    localparam int CNT_W   = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

    stage_t           f_q, d_q, x_q;
    logic             adv, busy, done, redir;
    logic [CNT_W-1:0] d_extra;

    tsp_stage_pipe #(.N_STG(3)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .redirect   (redir),
        .imem_ready (imem_ready),
        .fetch_cls  (op_class_e'(fetch_class)),
        .f_q        (f_q),
        .d_q        (d_q),
        .x_q        (x_q)
    );

    tsp_latency_map #(
        .LAT_BSHIFT (LAT_BSHIFT),
        .LAT_MUL    (LAT_MUL),
        .LAT_DIV    (LAT_DIV),
        .LAT_FPU    (LAT_FPU),
        .CNT_W      (CNT_W)
    ) u_lat (
        .cls   (d_q.cls),
        .extra (d_extra)
    );

    tsp_exec_tracker #(.CNT_W(CNT_W)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .load_vld   (d_q.vld && !redir),
        .load_extra (d_extra),
        .x_vld      (x_q.vld),
        .x_cls      (x_q.cls),
        .dmem_ready (dmem_ready),
        .strm_ready (strm_ready),
        .done       (done),
        .busy       (busy)
    );

    tsp_adv_ctrl u_ctrl (
        .busy         (busy),
        .done         (done),
        .x_cls        (x_q.cls),
        .branch_taken (branch_taken),
        .imem_ready   (imem_ready),
        .f_vld        (f_q.vld),
        .d_vld        (d_q.vld),
        .adv          (adv),
        .redirect     (redir),
        .f_en         (f_en),
        .d_en         (d_en),
        .x_en         (x_en),
        .stall        (stall)
    );

    assign f_valid  = f_q.vld;
    assign d_valid  = d_q.vld;
    assign x_valid  = x_q.vld;
    assign x_class  = x_q.cls;
    assign x_retire = done;
    assign redirect = redir;
endmodule

// File: rtl/tsp_pipe_checker.sv
// Protocol checker for the stall controller, attached by bind.
// Observes ports only and keeps its own count of Execute occupancy.
module tsp_pipe_checker #(
    parameter int LAT_BSHIFT = 2,
    parameter int LAT_MUL    = 3,
    parameter int LAT_DIV    = 32,
    parameter int LAT_FPU    = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dmem_ready,
    input logic       strm_ready,
    input logic       f_valid,
    input logic       d_valid,
    input logic       x_valid,
    input logic [3:0] x_class,
    input logic       f_en,
    input logic       x_en,
    input logic       stall,
    input logic       x_retire,
    input logic       redirect
);
    int occ;

    function automatic int lat_of(input logic [3:0] c);
        case (c)
            4'd5:    return LAT_BSHIFT;
            4'd6:    return LAT_MUL;
            4'd7:    return LAT_DIV;
            4'd8:    return LAT_FPU;
            default: return 1;
        endcase
    endfunction

    // Cycles the current Execute occupant has spent there, counting this one.
    always_ff @(posedge clk) begin
        if (!rst_n || !x_valid || x_retire) occ <= 1;
        else                                occ <= occ + 1;
    end

    assert_stall_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !f_en);

    assert_enter_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        x_en |=> x_valid);

    assert_exact_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (x_retire && x_class >= 4'd5) |-> (occ == lat_of(x_class)));

    assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && !x_retire) |=>
            (x_valid && $stable(x_class) && $stable(d_valid) && $stable(f_valid)));

    assert_dmem_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && (x_class == 4'd2 || x_class == 4'd3) && !dmem_ready) |-> !x_retire);

    assert_strm_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && x_class == 4'd4 && !strm_ready) |-> !x_retire);

    assert_redirect_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (x_retire && x_class == 4'd1));

    assert_flush_bubbles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!d_valid && !x_valid));
endmodule

bind tri_stage_pipe_ctrl tsp_pipe_checker #(
    .LAT_BSHIFT (LAT_BSHIFT),
    .LAT_MUL    (LAT_MUL),
    .LAT_DIV    (LAT_DIV),
    .LAT_FPU    (LAT_FPU)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dmem_ready (dmem_ready),
    .strm_ready (strm_ready),
    .f_valid    (f_valid),
    .d_valid    (d_valid),
    .x_valid    (x_valid),
    .x_class    (x_class),
    .f_en       (f_en),
    .x_en       (x_en),
    .stall      (stall),
    .x_retire   (x_retire),
    .redirect   (redirect)
);

// File: tb/tri_stage_pipe_ctrl_tb_top.sv
// Self-checking bench: class-pair sweep plus directed stall and flush cases.
module tri_stage_pipe_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       imem_ready = 1'b1, dmem_ready = 1'b1, strm_ready = 1'b1, branch_taken = 1'b0;
    logic [3:0] fetch_class;
    logic       f_valid, d_valid, x_valid, f_en, d_en, x_en, stall, x_retire, redirect;
    logic [3:0] x_class;

    int n_vec = 0, n_bad = 0, cyc = 0, ptr = 0, rn = 0;
    logic [3:0] prog [256];
    logic [3:0] rlog [256];
    int         rcyc [256];

    always #10 clk = ~clk;

    assign fetch_class = prog[ptr % 256];

    tri_stage_pipe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_class(fetch_class), .imem_ready(imem_ready),
        .dmem_ready(dmem_ready), .strm_ready(strm_ready), .branch_taken(branch_taken),
        .f_valid(f_valid), .d_valid(d_valid), .x_valid(x_valid), .x_class(x_class),
        .f_en(f_en), .d_en(d_en), .x_en(x_en), .stall(stall), .x_retire(x_retire),
        .redirect(redirect)
    );

    // Fetch pointer and retire log.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            ptr <= 0;
            rn  <= 0;
        end else begin
            if (f_en) ptr <= ptr + 1;
            if (x_retire && rn < 256) begin
                rlog[rn] <= x_class;
                rcyc[rn] <= cyc;
                rn <= rn + 1;
            end
        end
    end

    function automatic int exp_lat(input int c);
        case (c)
            5: return 2;
            6: return 3;
            7: return 32;
            8: return 4;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill_prog(input int c0, input int c1, input int c2, input int c3, input int c4);
        for (int i = 0; i < 256; i++) prog[i] = 4'd0;
        prog[0] = 4'(c0); prog[1] = 4'(c1); prog[2] = 4'(c2); prog[3] = 4'(c3); prog[4] = 4'(c4);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        imem_ready = 1'b1; dmem_ready = 1'b1; strm_ready = 1'b1; branch_taken = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_exec(input int cls);
        int g = 0;
        while (!(x_valid && x_class == 4'(cls)) && g < 200) begin
            @(negedge clk);
            g++;
        end
        chk(g < 200, "R3 reach execute", g, 0);
    endtask

    // R6/R7/R10: a waiting access, then a plain op that ignores the ready line.
    task automatic mem_case(input int cls, input bit use_strm, input string rq);
        fill_prog(cls, 0, 0, 0, 0);
        do_reset();
        if (use_strm) strm_ready = 1'b0; else dmem_ready = 1'b0;
        wait_exec(cls);
        for (int j = 0; j < 5; j++) begin
            chk(x_valid && !x_retire && stall && !d_en, {rq, " wait holds"}, x_retire, 0);
            @(negedge clk);
        end
        if (use_strm) strm_ready = 1'b1; else dmem_ready = 1'b1;
        #1;
        chk(x_retire == 1'b1, {rq, " retire on ready"}, x_retire, 1);
        @(negedge clk);
        if (use_strm) strm_ready = 1'b0; else dmem_ready = 1'b0;
        #1;
        chk(x_valid && x_class == 4'd0 && x_retire, "R10 plain op ignores ready", x_retire, 1);
        strm_ready = 1'b1; dmem_ready = 1'b1;
    endtask

    initial begin
        int k, g, busy_n;
        bit fv_p, dv_p;
        // R1: reset state
        for (int i = 0; i < 256; i++) prog[i] = 4'd0;
        repeat (3) @(negedge clk);
        chk(!f_valid && !d_valid && !x_valid, "R1 valids clear", {f_valid, d_valid, x_valid}, 0);
        chk(!x_retire && !redirect, "R1 no retire or redirect", {x_retire, redirect}, 0);

        // R3/R4/R9: every ordered pair of classes, back to back
        k = 0;
        for (int a = 0; a < 9; a++)
            for (int b = 0; b < 9; b++) begin
                prog[k] = 4'(a); prog[k+1] = 4'(b); k += 2;
            end
        for (int i = k; i < 256; i++) prog[i] = 4'd0;
        rst_n = 1'b1;
        g = 0;
        while (rn < 162 && g < 6000) begin @(negedge clk); g++; end
        chk(rn >= 162, "R9 all retired", rn, 162);
        for (int i = 0; i < 162; i++)
            chk(rlog[i] == prog[i], "R9 retire order", rlog[i], prog[i]);
        for (int i = 1; i < 162; i++)
            chk(rcyc[i] - rcyc[i-1] == exp_lat(prog[i]),
                (prog[i] >= 5) ? "R4 latency gap" : "R3 single-cycle gap",
                rcyc[i] - rcyc[i-1], exp_lat(prog[i]));

        // R2: fetch readiness pattern with plain ops
        fill_prog(0, 0, 0, 0, 0);
        do_reset();
        fv_p = 1'b0; dv_p = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(f_valid == imem_ready, "R2 fetch capture", f_valid, imem_ready);
            chk(stall == !imem_ready && f_en == imem_ready, "R2 stall on fetch", stall, !imem_ready);
            if (i > 0) chk(d_valid == fv_p && x_valid == dv_p, "R3 bubble flow", {d_valid, x_valid}, {fv_p, dv_p});
            fv_p = f_valid; dv_p = d_valid;
            imem_ready = (i % 3 != 2);
        end
        imem_ready = 1'b1;

        // R5: divide freezes upstream stages
        fill_prog(7, 0, 0, 0, 0);
        do_reset();
        wait_exec(7);
        busy_n = 0;
        while (!x_retire && busy_n < 100) begin
            chk(stall && !f_en && !d_en && !x_en && f_valid && d_valid, "R5 freeze", {stall, f_en, d_en, x_en}, 8);
            busy_n++;
            @(negedge clk);
        end
        chk(busy_n == exp_lat(7) - 1, "R5 busy cycles", busy_n, exp_lat(7) - 1);
        @(negedge clk);
        chk(x_valid && x_class == 4'd0, "R5 next enters after retire", x_class, 0);

        mem_case(2, 1'b0, "R6 load");
        mem_case(3, 1'b0, "R6 store");
        mem_case(4, 1'b1, "R7 stream");

        // R8: taken-branch flush, branch_taken held across a busy multiply
        fill_prog(6, 1, 6, 7, 8);
        do_reset();
        branch_taken = 1'b1;
        g = 0;
        while (!redirect && g < 100) begin
            @(negedge clk);
            if (x_valid && x_class != 4'd1) chk(!redirect, "R8 no redirect for non-branch", redirect, 0);
            g++;
        end
        chk(redirect && x_class == 4'd1, "R8 redirect on branch", x_class, 1);
        @(negedge clk);
        branch_taken = 1'b0;
        chk(!d_valid && !x_valid && f_valid, "R8 two bubbles", {f_valid, d_valid, x_valid}, 4);
        g = 0;
        while (rn < 3 && g < 100) begin @(negedge clk); g++; end
        chk(rlog[0] == 4'd6, "R8 first retire", rlog[0], 6);
        chk(rlog[1] == 4'd1, "R8 branch retire", rlog[1], 1);
        chk(rlog[2] == 4'd8, "R8 target after flush", rlog[2], 8);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule